// File: doc/BRIEF.md
# AC97 Link Frame Controller

This block is the controller end of an AC97 serial link. The codec supplies the serial bit clock, and the block runs entirely in that clock domain. From this clock it derives a fixed 256-bit frame. The frame opens with a 16-bit tag slot, and twelve 20-bit data slots follow it. A frame-sync output is high for the whole tag slot. In each frame the block shifts one 256-bit word out to the codec and captures one 256-bit word from it. Both directions send the most significant bit first.

On the system side, transmit words arrive over a valid/ready handshake. They are held in a one-frame buffer and go out in the next frame. Each received frame is handed back as a single 256-bit word with a valid/ready handshake. If the transmit buffer is empty when a frame starts, the block sends a frame of zeros and raises an underrun pulse. If a received word is still unclaimed when the next frame completes, the block raises an overrun pulse. A separate reset output to the codec follows a software-driven request bit and does not depend on the frame logic. The divide ratio and the sync width are fixed. No input changes them.

Top module: `ac97_link_ctrl`

## Requirements
- R1: `frame_sync` repeats every 256 `serial_clk` cycles. It is high for exactly 16 consecutive cycles, which are frame bits 0 to 15 (the tag slot), and low for the other 240. The first high cycle follows the first rising edge after `rst` is released.
- R2: `ser_out` changes only on rising edges of `serial_clk`. For frame bit k (k = 0..255, bit 0 being the cycle where `frame_sync` first goes high), it carries bit 255-k of the transmitted word, so word bit 255 goes first.
- R3: `tx_ready` is high exactly when the one-frame transmit buffer is empty. A word is accepted on a rising edge where `tx_valid` and `tx_ready` are both high. The accepted word is sent in the next frame. `tx_ready` stays low until that frame starts, and a word offered while `tx_ready` is low is neither taken nor sent.
- R4: When a frame starts with the transmit buffer empty, every bit of that frame on `ser_out` is 0. In that case `tx_underrun` is high for exactly the frame's first cycle (frame bit 0).
- R5: `ser_in` is sampled on the falling edge of `serial_clk` that lies inside each frame bit. In the delivered word, bit 255 holds the sample from frame bit 0 and bit 0 holds the sample from frame bit 255.
- R6: A received frame is presented on `rx_frame` with `rx_valid` high from frame bit 0 of the following frame. `rx_valid` and `rx_frame` hold steady until a rising edge with `rx_ready` high, which clears `rx_valid`. The first frame after reset is not delivered until the second frame starts.
- R7: If a received frame completes while `rx_valid` is still high and `rx_ready` is low, `rx_frame` is replaced by the newer word, `rx_valid` stays high, and `rx_overrun` is high for that one cycle.
- R8: While `rst` is high (synchronous, active high), `frame_sync`, `ser_out`, `rx_valid`, `tx_underrun` and `rx_overrun` are low. The bit counter is cleared and the transmit buffer is emptied, so `tx_ready` reads high.
- R9: `codec_reset_n` is low while `rst` is high. At other times it equals the inverse of `codec_reset_req` as sampled on the previous rising edge. It is independent of the frame position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| serial_clk | input | 1 | Bit clock supplied by the codec; sole clock of the block |
| rst | input | 1 | Synchronous active-high reset of the controller |
| codec_reset_req | input | 1 | Software request to hold the codec in reset |
| codec_reset_n | output | 1 | Active-low reset driven to the codec |
| frame_sync | output | 1 | Frame sync, high during the tag slot |
| ser_out | output | 1 | Serial data to the codec, MSB first |
| ser_in | input | 1 | Serial data from the codec, sampled on falling edges |
| tx_frame | input | 256 | Word to send in a later frame |
| tx_valid | input | 1 | `tx_frame` is offered |
| tx_ready | output | 1 | Transmit buffer is empty and can take a word |
| tx_underrun | output | 1 | Pulse: a frame started with no word buffered |
| rx_frame | output | 256 | Last completed received frame |
| rx_valid | output | 1 | `rx_frame` holds an unclaimed word |
| rx_ready | input | 1 | System side takes `rx_frame` |
| rx_overrun | output | 1 | Pulse: an unclaimed word was replaced |

## Verification
On every cycle, the assertions check these properties:
- the 16-high / 240-low rhythm of the sync output;
- the quiet outputs after reset;
- that a full transmit buffer blocks further writes;
- that an underrun frame starts with a zero on the serial output;
- that an unclaimed received word holds, except when an overrun replaces it;
- that the codec reset follows its request bit.

Only the bench's scenarios can show the following:
- the bit order on the serial pins in both directions;
- that a buffered word lands in exactly the next frame, and that a word offered into a full buffer is lost;
- that an underrun frame is zero in all 256 bits;
- the frame delay between capture and delivery;
- that after a reset in mid-frame the next frame starts cleanly.

// File: rtl/ac97_link_pkg.sv
package ac97_link_pkg;

  // Fixed slot layout of one link frame.
  localparam int unsigned TAG_SLOT_BITS  = 16;
  localparam int unsigned DATA_SLOT_BITS = 20;
  localparam int unsigned DATA_SLOTS     = 12;
  localparam int unsigned LINK_FRAME_BITS = TAG_SLOT_BITS + DATA_SLOTS * DATA_SLOT_BITS;

endpackage

// File: rtl/ac97_frame_timer.sv
module ac97_frame_timer
  import ac97_link_pkg::*;
#(
  parameter int unsigned FRAME_BITS = LINK_FRAME_BITS,
  parameter int unsigned TAG_BITS   = TAG_SLOT_BITS
) (
  input  logic clk,
  input  logic rst,
  output logic frame_start,
  output logic sync_o,
  output logic armed_o
);

  localparam int unsigned CNT_W = $clog2(FRAME_BITS);
  localparam bit          POW2  = ((FRAME_BITS & (FRAME_BITS - 1)) == 0);

  logic [CNT_W-1:0] bit_idx;
  logic [CNT_W-1:0] idx_next;

  // Wrap logic: a power-of-two frame wraps by itself, otherwise compare.
  generate
    if (POW2) begin : g_wrap_free
      assign idx_next = bit_idx + CNT_W'(1);
    end else begin : g_wrap_cmp
      assign idx_next = (bit_idx == CNT_W'(FRAME_BITS - 1)) ? '0 : bit_idx + CNT_W'(1);
    end
  endgenerate

  assign frame_start = (bit_idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_idx <= '0;
      sync_o  <= 1'b0;
      armed_o <= 1'b0;
    end else begin
      bit_idx <= idx_next;
      sync_o  <= (bit_idx < CNT_W'(TAG_BITS));
      if (frame_start) begin
        armed_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ac97_tx_path.sv
module ac97_tx_path
  import ac97_link_pkg::*;
#(
  parameter int unsigned FRAME_BITS = LINK_FRAME_BITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_start,
  input  logic [FRAME_BITS-1:0] tx_data,
  input  logic                  tx_valid,
  output logic                  tx_ready,
  output logic                  ser_out,
  output logic                  underrun
);

  logic [FRAME_BITS-1:0] hold_q;
  logic [FRAME_BITS-1:0] shift_q;
  logic                  full_q;
  logic                  take;

  assign tx_ready = ~full_q;
  assign take     = tx_valid & ~full_q;

  // Holding register: no reset so it maps onto plain flops.
  always_ff @(posedge clk) begin
    if (take) begin
      hold_q <= tx_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q   <= 1'b0;
      shift_q  <= '0;
      ser_out  <= 1'b0;
      underrun <= 1'b0;
    end else begin
      underrun <= 1'b0;
      if (frame_start) begin
        if (full_q) begin
          ser_out <= hold_q[FRAME_BITS-1];
          shift_q <= {hold_q[FRAME_BITS-2:0], 1'b0};
          full_q  <= 1'b0;
        end else begin
          ser_out  <= 1'b0;
          shift_q  <= '0;
          underrun <= 1'b1;
        end
      end else begin
        ser_out <= shift_q[FRAME_BITS-1];
        shift_q <= {shift_q[FRAME_BITS-2:0], 1'b0};
      end
      if (take) begin
        full_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ac97_rx_path.sv
module ac97_rx_path
  import ac97_link_pkg::*;
#(
  parameter int unsigned FRAME_BITS = LINK_FRAME_BITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ser_in,
  input  logic                  frame_start,
  input  logic                  armed,
  output logic [FRAME_BITS-1:0] rx_data,
  output logic                  rx_valid,
  input  logic                  rx_ready,
  output logic                  overrun
);

  logic                  fall_q;
  logic [FRAME_BITS-2:0] shift_q;
  logic                  complete;

  assign complete = frame_start & armed;

  // Falling-edge capture of the incoming bit.
  always_ff @(negedge clk) begin
    if (rst) begin
      fall_q <= 1'b0;
    end else begin
      fall_q <= ser_in;
    end
  end

  always_ff @(posedge clk) begin
    shift_q <= {shift_q[FRAME_BITS-3:0], fall_q};
  end

  always_ff @(posedge clk) begin
    if (complete) begin
      rx_data <= {shift_q, fall_q};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_valid <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      overrun <= 1'b0;
      if (complete) begin
        rx_valid <= 1'b1;
        overrun  <= rx_valid & ~rx_ready;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ac97_link_ctrl.sv
module ac97_link_ctrl
  import ac97_link_pkg::*;
#(
  parameter int unsigned FRAME_BITS = LINK_FRAME_BITS,
  parameter int unsigned TAG_BITS   = TAG_SLOT_BITS
) (
  input  logic                  serial_clk,
  input  logic                  rst,
  input  logic                  codec_reset_req,
  output logic                  codec_reset_n,
  output logic                  frame_sync,
  output logic                  ser_out,
  input  logic                  ser_in,
  input  logic [FRAME_BITS-1:0] tx_frame,
  input  logic                  tx_valid,
  output logic                  tx_ready,
  output logic                  tx_underrun,
  output logic [FRAME_BITS-1:0] rx_frame,
  output logic                  rx_valid,
  input  logic                  rx_ready,
  output logic                  rx_overrun
);

  logic frame_start;
  logic armed;

  ac97_frame_timer #(
    .FRAME_BITS(FRAME_BITS),
    .TAG_BITS  (TAG_BITS)
  ) u_timer (
    .clk        (serial_clk),
    .rst        (rst),
    .frame_start(frame_start),
    .sync_o     (frame_sync),
    .armed_o    (armed)
  );

  ac97_tx_path #(
    .FRAME_BITS(FRAME_BITS)
  ) u_tx (
    .clk        (serial_clk),
    .rst        (rst),
    .frame_start(frame_start),
    .tx_data    (tx_frame),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .ser_out    (ser_out),
    .underrun   (tx_underrun)
  );

  ac97_rx_path #(
    .FRAME_BITS(FRAME_BITS)
  ) u_rx (
    .clk        (serial_clk),
    .rst        (rst),
    .ser_in     (ser_in),
    .frame_start(frame_start),
    .armed      (armed),
    .rx_data    (rx_frame),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .overrun    (rx_overrun)
  );

  // Codec reset follows the software bit only.
  always_ff @(posedge serial_clk) begin
    if (rst) begin
      codec_reset_n <= 1'b0;
    end else begin
      codec_reset_n <= ~codec_reset_req;
    end
  end

endmodule

// File: rtl/ac97_link_ctrl_chk.sv
module ac97_link_ctrl_chk #(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned TAG_BITS   = 16
) (
  input logic                  serial_clk,
  input logic                  rst,
  input logic                  codec_reset_req,
  input logic                  codec_reset_n,
  input logic                  frame_sync,
  input logic                  ser_out,
  input logic                  tx_valid,
  input logic                  tx_ready,
  input logic                  tx_underrun,
  input logic [FRAME_BITS-1:0] rx_frame,
  input logic                  rx_valid,
  input logic                  rx_ready,
  input logic                  rx_overrun
);

  localparam int unsigned RUN_W = $clog2(FRAME_BITS) + 1;

  logic [RUN_W-1:0] run_q;
  logic             prev_q;
  logic             seen_q;

  always_ff @(posedge serial_clk) begin
    if (rst) begin
      run_q  <= '0;
      prev_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      prev_q <= frame_sync;
      if (frame_sync != prev_q) begin
        run_q <= RUN_W'(1);
        if (frame_sync) begin
          seen_q <= 1'b1;
        end
      end else begin
        run_q <= run_q + RUN_W'(1);
      end
    end
  end

  // R1
  sync_width_chk: assert property (@(posedge serial_clk) disable iff (rst)
    (prev_q && !frame_sync) |-> (run_q == RUN_W'(TAG_BITS)));

  // R1
  sync_gap_chk: assert property (@(posedge serial_clk) disable iff (rst)
    (!prev_q && frame_sync && seen_q) |-> (run_q == RUN_W'(FRAME_BITS - TAG_BITS)));

  // R8
  reset_quiet_chk: assert property (@(posedge serial_clk)
    rst |=> (!frame_sync && !ser_out && !rx_valid && tx_ready));

  // R3
  tx_hold_chk: assert property (@(posedge serial_clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R4
  underrun_zero_chk: assert property (@(posedge serial_clk) disable iff (rst)
    tx_underrun |-> (frame_sync && !ser_out));

  // R6
  rx_hold_chk: assert property (@(posedge serial_clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && ($stable(rx_frame) || rx_overrun)));

  // R7
  overrun_valid_chk: assert property (@(posedge serial_clk) disable iff (rst)
    rx_overrun |-> rx_valid);

  // R7
  overrun_pulse_chk: assert property (@(posedge serial_clk) disable iff (rst)
    rx_overrun |=> !rx_overrun);

  // R9
  codec_rst_chk: assert property (@(posedge serial_clk) disable iff (rst)
    !rst |=> (codec_reset_n == !$past(codec_reset_req)));

endmodule

bind ac97_link_ctrl ac97_link_ctrl_chk #(
  .FRAME_BITS(FRAME_BITS),
  .TAG_BITS  (TAG_BITS)
) u_chk (
  .serial_clk     (serial_clk),
  .rst            (rst),
  .codec_reset_req(codec_reset_req),
  .codec_reset_n  (codec_reset_n),
  .frame_sync     (frame_sync),
  .ser_out        (ser_out),
  .tx_valid       (tx_valid),
  .tx_ready       (tx_ready),
  .tx_underrun    (tx_underrun),
  .rx_frame       (rx_frame),
  .rx_valid       (rx_valid),
  .rx_ready       (rx_ready),
  .rx_overrun     (rx_overrun)
);

// File: tb/ac97_link_ctrl_tb.sv
module ac97_link_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int FB = 256;

  logic          serial_clk = 1'b0;
  logic          rst = 1'b1;
  logic          codec_reset_req = 1'b0;
  logic          codec_reset_n;
  logic          frame_sync;
  logic          ser_out;
  logic          ser_in = 1'b0;
  logic [FB-1:0] tx_frame = '0;
  logic          tx_valid = 1'b0;
  logic          tx_ready;
  logic          tx_underrun;
  logic [FB-1:0] rx_frame;
  logic          rx_valid;
  logic          rx_ready = 1'b0;
  logic          rx_overrun;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  done = 0;

  // Bench model state
  bit            m_full, m_pend, m_have_prev;
  logic [FB-1:0] m_buf, m_pword, m_prev;

  always #(CLK_PERIOD/2) serial_clk = ~serial_clk;

  ac97_link_ctrl u_dut (
    .serial_clk     (serial_clk),
    .rst            (rst),
    .codec_reset_req(codec_reset_req),
    .codec_reset_n  (codec_reset_n),
    .frame_sync     (frame_sync),
    .ser_out        (ser_out),
    .ser_in         (ser_in),
    .tx_frame       (tx_frame),
    .tx_valid       (tx_valid),
    .tx_ready       (tx_ready),
    .tx_underrun    (tx_underrun),
    .rx_frame       (rx_frame),
    .rx_valid       (rx_valid),
    .rx_ready       (rx_ready),
    .rx_overrun     (rx_overrun)
  );

  task automatic chk(input bit ok, input string tag, input logic [FB-1:0] act, input logic [FB-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [FB-1:0] rand_word();
    logic [FB-1:0] w = '0;
    for (int i = 0; i < FB/32; i++) w = {w[FB-33:0], $urandom()};
    return w;
  endfunction

  task automatic do_reset(input int cycles);
    rst = 1'b1;
    tx_valid = 1'b0;
    rx_ready = 1'b0;
    for (int i = 0; i < cycles; i++) @(posedge serial_clk);
    #2;
    // R8: quiet outputs and empty buffer while held in reset
    chk(frame_sync === 1'b0, "R8 frame_sync in reset", FB'(frame_sync), '0);
    chk(ser_out === 1'b0, "R8 ser_out in reset", FB'(ser_out), '0);
    chk(rx_valid === 1'b0 && tx_underrun === 1'b0 && rx_overrun === 1'b0,
        "R8 flags in reset", FB'({rx_valid, tx_underrun, rx_overrun}), '0);
    chk(tx_ready === 1'b1, "R8 tx_ready in reset", FB'(tx_ready), FB'(1));
    // R9: codec held in reset while controller resets
    chk(codec_reset_n === 1'b0, "R9 codec_reset_n in reset", FB'(codec_reset_n), '0);
    rst = 1'b0;
    m_full = 0; m_pend = 0; m_have_prev = 0;
  endtask

  // One full frame: codec word cw, optional pushes at bits 5 and 100, optional take.
  task automatic run_frame(input logic [FB-1:0] cw, input bit push1, input logic [FB-1:0] w1,
                           input bit push2, input logic [FB-1:0] w2, input bit take);
    logic [FB-1:0] got;
    logic [FB-1:0] exp_tx;
    logic [FB-1:0] offered;
    int            sync_bad;
    bit            exp_ov;
    bit            took;
    sync_bad = 0;
    exp_tx = '0;
    offered = '0;
    took = 0;
    for (int k = 0; k < FB; k++) begin
      @(posedge serial_clk);
      #2;
      got[FB-1-k] = ser_out;
      if (frame_sync !== (k < 16)) sync_bad++;
      if (k == 0) begin
        exp_tx = m_full ? m_buf : '0;
        // R4: underrun pulse exactly when buffer empty at frame start
        chk(tx_underrun === !m_full, "R4 tx_underrun at frame start", FB'(tx_underrun), FB'(!m_full));
        m_full = 0;
        exp_ov = 0;
        if (m_have_prev) begin
          exp_ov = m_pend;
          m_pend = 1;
          m_pword = m_prev;
        end
        // R6: delivery at frame bit 0 of the next frame
        chk(rx_valid === m_pend, "R6 rx_valid at frame start", FB'(rx_valid), FB'(m_pend));
        if (m_pend) begin
          // R5: MSB is the first sampled bit
          chk(rx_frame === m_pword, "R5 rx_frame content", rx_frame, m_pword);
        end
        // R7: overrun only when old word was unclaimed
        chk(rx_overrun === exp_ov, "R7 rx_overrun", FB'(rx_overrun), FB'(exp_ov));
      end
      if (k == 1) begin
        chk(tx_underrun === 1'b0 && rx_overrun === 1'b0, "R4 R7 flags one cycle only",
            FB'({tx_underrun, rx_overrun}), '0);
      end
      if (k == 2 && take && m_pend) rx_ready = 1'b1;
      if (k == 3) begin
        if (rx_ready) begin
          rx_ready = 1'b0;
          m_pend = 0;
          chk(rx_valid === 1'b0, "R6 rx_valid cleared after take", FB'(rx_valid), '0);
        end else if (m_pend) begin
          chk(rx_valid === 1'b1 && rx_frame === m_pword, "R6 rx word held", rx_frame, m_pword);
        end
      end
      if ((k == 5 && push1) || (k == 100 && push2)) begin
        // R3: ready reflects buffer state
        chk(tx_ready === !m_full, "R3 tx_ready before offer", FB'(tx_ready), FB'(!m_full));
        offered = (k == 5) ? w1 : w2;
        tx_frame = offered;
        tx_valid = 1'b1;
        took = 1;
      end
      if ((k == 6 || k == 101) && took) begin
        tx_valid = 1'b0;
        took = 0;
        if (!m_full) begin
          m_full = 1;
          m_buf = offered;
        end
        chk(tx_ready === 1'b0, "R3 tx_ready low with buffer full", FB'(tx_ready), '0);
      end
      if (k == 10) codec_reset_req = 1'($urandom() % 2);
      if (k == 11) begin
        chk(codec_reset_n === !codec_reset_req, "R9 codec_reset_n follows request",
            FB'(codec_reset_n), FB'(!codec_reset_req));
      end
      ser_in = cw[FB-1-k];
    end
    // R2: serial output bits in MSB-first order (zeros when underrun, R4)
    chk(got === exp_tx, "R2 R4 ser_out frame content", got, exp_tx);
    // R1: 16 high, 240 low
    chk(sync_bad == 0, "R1 frame_sync shape", FB'(sync_bad), '0);
    m_prev = cw;
    m_have_prev = 1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset(4);
    // Directed corners
    run_frame(rand_word(), 1, {FB{1'b1}}, 0, '0, 1);                   // first frame underruns
    run_frame({FB{1'b1}}, 1, {(FB/4){4'hA}}, 1, {FB{1'b1}}, 1);       // second offer rejected
    run_frame({(FB/4){4'h5}}, 0, '0, 0, '0, 1);                        // nothing queued
    run_frame(rand_word(), 0, '0, 1, rand_word(), 0);                  // late push only; no take
    run_frame(rand_word(), 1, rand_word(), 0, '0, 0);                  // overrun expected next
    run_frame(rand_word(), 1, '0, 0, '0, 1);
    // Random frames
    for (int f = 0; f < 8; f++) begin
      run_frame(rand_word(), 1'($urandom() % 2), rand_word(), 1'($urandom() % 2), rand_word(),
                1'($urandom() % 2));
    end
    // Mid-frame reset, then a clean restart
    for (int i = 0; i < 77; i++) @(posedge serial_clk);
    #2;
    do_reset(3);
    for (int f = 0; f < 4; f++) begin
      run_frame(rand_word(), 1'($urandom() % 2), rand_word(), 0, '0, 1'($urandom() % 2));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule